// File: doc/BRIEF.md
# Burst Bus Master Sequencer

This block is the master side of one cache-line move on a synchronous external bus. An internal requester hands it a byte address and a direction. The block then opens a burst on the bus for the 16-byte line that holds that address. The burst starts at the word the address points to. The sequencer counts the beats the slave acknowledges and tells the requester when each beat carries data and when the line is complete.

Two slave responses change the plan. Suppose the memory controller reports, before any acknowledge, that the port is narrower than 32 bits and accepts the burst. The burst then grows to 8 or 16 beats, and the bus stays locked until the last one. Suppose instead the slave refuses to burst on the first acknowledge. The sequencer drops the burst and moves the rest of the line as separate single transfers. Their number depends on the port width the slave reports, and their addresses step through the line with wrap-around.

Top module: `burst_seq`

## Requirements
- R1: While reset is held and while idle, all bus outputs (`ts_o`, `burst_o`, `bdip_o`, `write_o`, `lock_o`, `beat_o`, `done_o`) are 0 and `addr_o` is 0.
- R2: The cycle after `req_valid` is taken in idle, `ts_o` is 1 for exactly one cycle. In that cycle `burst_o` is 1, `write_o` equals the requested direction, and `addr_o` is the request address with its two low bits cleared. Address, direction and `burst_o` stay unchanged until the burst ends.
- R3: A beat completes only in a cycle where `ta_i` is 1. `beat_o` is 1 exactly in the cycles of an active transfer where `ta_i` is 1.
- R4: During a burst, `bdip_o` is 1 on every beat that a further beat follows and 0 on the last beat. Outside a burst it is 0.
- R5: With no port report and no refusal, the burst has 4 beats. `done_o` is 1 together with the fourth acknowledge, and the next cycle the block is idle.
- R6: `psize_vld_i` during a burst cycle before the first acknowledge (and without `ta_i`) sets the burst length from `psize_i`: 01 (16-bit port) gives 8 beats, 10 (8-bit port) gives 16 beats, and 00 or 11 gives 4 beats. A report after the first acknowledge has no effect.
- R7: After a report of 01 or 10, `lock_o` is 1 from the next cycle through the cycle of the final acknowledge. It is 0 in all other cycles.
- R8: If `bi_i` is 1 with the first acknowledge of a burst, that beat counts, `done_o` stays 0, and the burst ends. It is followed by 3, 7 or 15 single transfers, with `psize_i` sampled on that beat coded as in R6. `bi_i` on any later beat has no effect.
- R9: Each fallback single transfer starts with a one-cycle `ts_o`, with `burst_o` and `bdip_o` at 0. The address of the k-th transfer is the line base plus ((start byte offset + k * width) mod 16), where width is 4, 2 or 1 bytes. `done_o` comes with the last of them.
- R10: `req_valid` is ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Line transfer request, taken when idle |
| req_addr | input | AW | Byte address inside the line to move |
| req_write | input | 1 | 1 for a write, 0 for a read |
| ts_o | output | 1 | Transfer start strobe |
| burst_o | output | 1 | Current transfer is a burst |
| bdip_o | output | 1 | More burst beats follow the current one |
| write_o | output | 1 | Direction of the current transfer |
| addr_o | output | AW | Bus address |
| lock_o | output | 1 | Bus held for an extended burst |
| ta_i | input | 1 | Slave transfer acknowledge |
| bi_i | input | 1 | Slave refuses to burst |
| psize_vld_i | input | 1 | Port size report with burst accepted |
| psize_i | input | 2 | Port width code: 00 32-bit, 01 16-bit, 10 8-bit |
| beat_o | output | 1 | Data valid for this beat, to the requester |
| done_o | output | 1 | Final beat of the line, to the requester |

## Verification
The bench runs normal 4-beat bursts from every start word and in both directions. It also runs bursts stretched by each port code, including the codes that must leave the length at 4, which separates a correct decode from one that always lengthens. It runs refused bursts for each fallback width, which shows whether the single-transfer addresses wrap correctly from starts near the end of the line. Random wait states, late port reports, late refusals and requests made while busy show whether those inputs are ignored at the points where they must be.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BURST  = 2'd1,
        ST_SINGLE = 2'd2
    } seq_state_e;

    localparam logic [1:0] PORT_W32 = 2'b00;
    localparam logic [1:0] PORT_W16 = 2'b01;
    localparam logic [1:0] PORT_W8  = 2'b10;

endpackage

// File: rtl/bs_port_decode.sv
module bs_port_decode #(
    parameter int LINE_BYTES = 16,
    parameter int WORD_BYTES = 4,
    localparam int OW = $clog2(LINE_BYTES)
) (
    input  logic [1:0]    code_i,
    output logic [OW-1:0] step_o,
    output logic [OW-1:0] last_o,
    output logic          narrow_o
);
    import burst_seq_pkg::*;

    always_comb begin
        unique case (code_i)
            PORT_W16: begin
                step_o   = OW'(WORD_BYTES / 2);
                last_o   = OW'(2 * LINE_BYTES / WORD_BYTES - 1);
                narrow_o = 1'b1;
            end
            PORT_W8: begin
                step_o   = OW'(WORD_BYTES / 4);
                last_o   = OW'(4 * LINE_BYTES / WORD_BYTES - 1);
                narrow_o = 1'b1;
            end
            default: begin
                step_o   = OW'(WORD_BYTES);
                last_o   = OW'(LINE_BYTES / WORD_BYTES - 1);
                narrow_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bs_off_step.sv
module bs_off_step #(
    parameter int OW = 4
) (
    input  logic [OW-1:0] off_i,
    input  logic [OW-1:0] step_i,
    output logic [OW-1:0] next_o
);
    // offset arithmetic is modulo the line size: wrap is the natural overflow
    assign next_o = off_i + step_i;
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    output logic          ts_o,
    output logic          burst_o,
    output logic          bdip_o,
    output logic          write_o,
    output logic [AW-1:0] addr_o,
    output logic          lock_o,
    input  logic          ta_i,
    input  logic          bi_i,
    input  logic          psize_vld_i,
    input  logic [1:0]    psize_i,
    output logic          beat_o,
    output logic          done_o
);
    import burst_seq_pkg::*;

    localparam int OW = $clog2(LINE_BYTES);
    localparam int LW = AW - OW;
    localparam logic [OW-1:0] WORD_LAST = OW'(LINE_BYTES / WORD_BYTES - 1);
    localparam logic [OW-1:0] WORD_MASK = ~OW'(WORD_BYTES - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [LW-1:0] line;
        logic [OW-1:0] off;
        logic [OW-1:0] cnt;
        logic [OW-1:0] last;
        logic [OW-1:0] step;
        logic          wr;
        logic          ts;
        logic          lock;
        logic          sized;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [OW-1:0] dec_step, dec_last, step_sel, off_next;
    logic          dec_narrow;
    logic          busy;

    bs_port_decode #(
        .LINE_BYTES(LINE_BYTES),
        .WORD_BYTES(WORD_BYTES)
    ) dec_i (
        .code_i  (psize_i),
        .step_o  (dec_step),
        .last_o  (dec_last),
        .narrow_o(dec_narrow)
    );

    assign step_sel = (seq_q.st == ST_BURST) ? dec_step : seq_q.step;

    bs_off_step #(.OW(OW)) step_i (
        .off_i (seq_q.off),
        .step_i(step_sel),
        .next_o(off_next)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.st    = ST_BURST;
                    seq_d.line  = req_addr[AW-1:OW];
                    seq_d.off   = req_addr[OW-1:0] & WORD_MASK;
                    seq_d.wr    = req_write;
                    seq_d.ts    = 1'b1;
                    seq_d.cnt   = '0;
                    seq_d.last  = WORD_LAST;
                    seq_d.step  = OW'(WORD_BYTES);
                    seq_d.lock  = 1'b0;
                    seq_d.sized = 1'b0;
                end
            end
            ST_BURST: begin
                seq_d.ts = 1'b0;
                if (!ta_i) begin
                    if (psize_vld_i && !seq_q.sized && seq_q.cnt == '0) begin
                        seq_d.sized = 1'b1;
                        seq_d.last  = dec_last;
                        seq_d.lock  = dec_narrow;
                    end
                end else if (bi_i && seq_q.cnt == '0) begin
                    seq_d.st   = ST_SINGLE;
                    seq_d.cnt  = OW'(1);
                    seq_d.last = dec_last;
                    seq_d.step = dec_step;
                    seq_d.off  = off_next;
                    seq_d.ts   = 1'b1;
                    seq_d.lock = 1'b0;
                end else if (seq_q.cnt == seq_q.last) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.lock = 1'b0;
                end else begin
                    seq_d.cnt   = seq_q.cnt + OW'(1);
                    seq_d.sized = 1'b1;
                end
            end
            ST_SINGLE: begin
                seq_d.ts = 1'b0;
                if (ta_i) begin
                    if (seq_q.cnt == seq_q.last) begin
                        seq_d.st = ST_IDLE;
                    end else begin
                        seq_d.cnt = seq_q.cnt + OW'(1);
                        seq_d.off = off_next;
                        seq_d.ts  = 1'b1;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy    = (seq_q.st != ST_IDLE);
    assign ts_o    = seq_q.ts;
    assign burst_o = (seq_q.st == ST_BURST);
    assign bdip_o  = burst_o && (seq_q.cnt != seq_q.last);
    assign write_o = busy && seq_q.wr;
    assign addr_o  = busy ? {seq_q.line, seq_q.off} : '0;
    assign lock_o  = seq_q.lock;
    assign beat_o  = busy && ta_i;
    assign done_o  = beat_o && (seq_q.cnt == seq_q.last) &&
                     !(burst_o && bi_i && seq_q.cnt == '0);
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ts_o,
    input logic          burst_o,
    input logic          bdip_o,
    input logic [AW-1:0] addr_o,
    input logic          lock_o,
    input logic          ta_i,
    input logic          beat_o,
    input logic          done_o
);
    AST_TS_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ts_o && !ta_i |=> !ts_o); // R2
    AST_BURST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        burst_o && $past(burst_o) |-> $stable(addr_o)); // R2
    AST_BEAT_NEEDS_TA: assert property (@(posedge clk) disable iff (!rst_n)
        beat_o |-> ta_i); // R3
    AST_BDIP_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        bdip_o |-> burst_o); // R4
    AST_LAST_BEAT_NO_BDIP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> beat_o && !bdip_o); // R4
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !burst_o && !ts_o && !lock_o); // R5
    AST_LOCK_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> burst_o); // R7
endmodule

bind burst_seq burst_seq_chk #(.AW(AW)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ts_o   (ts_o),
    .burst_o(burst_o),
    .bdip_o (bdip_o),
    .addr_o (addr_o),
    .lock_o (lock_o),
    .ta_i   (ta_i),
    .beat_o (beat_o),
    .done_o (done_o)
);

// File: tb/burst_seq_tb_top.sv
module burst_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        ta_i = 1'b0, bi_i = 1'b0, psize_vld_i = 1'b0;
    logic [1:0]  psize_i = 2'b00;
    logic        ts_o, burst_o, bdip_o, write_o, lock_o, beat_o, done_o;
    logic [31:0] addr_o;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;

    burst_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .ts_o(ts_o), .burst_o(burst_o), .bdip_o(bdip_o),
        .write_o(write_o), .addr_o(addr_o), .lock_o(lock_o), .ta_i(ta_i),
        .bi_i(bi_i), .psize_vld_i(psize_vld_i), .psize_i(psize_i),
        .beat_o(beat_o), .done_o(done_o)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int beats_of(logic [1:0] code);
        case (code)
            2'b01:   return 8;
            2'b10:   return 16;
            default: return 4;
        endcase
    endfunction

    // sample one cycle after inputs were driven at the falling edge
    task automatic cyc(string ctx, bit ts, bit bu, bit bd, logic [31:0] a,
                       bit lk, bit bt, bit dn, bit wr);
        #1;
        chk({"R2 ts ", ctx}, ts_o, ts);
        chk({"R2 burst ", ctx}, burst_o, bu);
        chk({"R4 bdip ", ctx}, bdip_o, bd);
        chk({"R2/R9 addr ", ctx}, addr_o, a);
        chk({"R7 lock ", ctx}, lock_o, lk);
        chk({"R3 beat ", ctx}, beat_o, bt);
        chk({"R5/R8 done ", ctx}, done_o, dn);
        chk({"R2 write ", ctx}, write_o, wr);
        @(negedge clk);
    endtask

    task automatic run_txn(logic [31:0] addr, bit wr, bit refuse,
                           bit rep_en, logic [1:0] rep_code, logic [1:0] fb_code);
        logic [31:0] line  = {addr[31:4], 4'h0};
        int          start = {addr[3:2], 2'b00};
        int          total = 4;
        bit          lk    = 1'b0;
        bit          tsp   = 1'b1;
        bit          fb    = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0; req_addr = $urandom; req_write = ~wr;
        if (rep_en) begin
            psize_vld_i = 1'b1; psize_i = rep_code;
            cyc("R6 report", tsp, 1, 1, line + start, 0, 0, 0, wr);
            tsp = 1'b0; psize_vld_i = 1'b0;
            total = beats_of(rep_code);
            lk = (total > 4);
        end
        for (int k = 0; k < total; k++) begin
            int nw = $urandom_range(0, 2);
            for (int w = 0; w < nw; w++) begin
                req_valid = $urandom_range(0, 1);     // R10: ignored while busy
                if (k > 0) begin
                    psize_vld_i = $urandom_range(0, 1); // R6: late report ignored
                    psize_i = 2'b10;
                end
                cyc("R3 wait", tsp, 1, k < total - 1, line + start, lk, 0, 0, wr);
                tsp = 1'b0; req_valid = 1'b0; psize_vld_i = 1'b0;
            end
            ta_i = 1'b1;
            fb   = (k == 0) && refuse;
            bi_i = (k == 0) ? refuse : 1'($urandom_range(0, 1)); // R8: late refusal ignored
            psize_i = fb_code;
            cyc("R5 burst beat", tsp, 1, k < total - 1, line + start, lk, 1,
                !fb && (k == total - 1), wr);
            tsp = 1'b0; ta_i = 1'b0; bi_i = 1'b0;
            if (fb) break;
        end
        if (fb) begin
            int n = beats_of(fb_code);
            int w = 16 / n;
            for (int k = 1; k < n; k++) begin
                logic [31:0] a = line + ((start + k * w) % 16);
                int nw = $urandom_range(0, 2);
                tsp = 1'b1;
                for (int i = 0; i < nw; i++) begin
                    psize_vld_i = $urandom_range(0, 1);
                    cyc("R9 single wait", tsp, 0, 0, a, 0, 0, 0, wr);
                    tsp = 1'b0; psize_vld_i = 1'b0;
                end
                ta_i = 1'b1; bi_i = $urandom_range(0, 1);
                cyc("R9 single beat", tsp, 0, 0, a, 0, 1, k == n - 1, wr);
                tsp = 1'b0; ta_i = 1'b0; bi_i = 1'b0;
            end
        end
        cyc("R5/R1 idle after", 0, 0, 0, 32'h0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7351));
        repeat (3) @(negedge clk);
        cyc("R1 in reset", 0, 0, 0, 32'h0, 0, 0, 0, 0);
        rst_n = 1'b1;
        cyc("R1 after reset", 0, 0, 0, 32'h0, 0, 0, 0, 0);

        // R5: plain bursts from several start words, both directions
        run_txn(32'h1000_0000, 1'b0, 0, 0, 2'b00, 2'b00);
        run_txn(32'h2000_004F, 1'b1, 0, 0, 2'b00, 2'b00);
        run_txn(32'h3000_0109, 1'b0, 0, 0, 2'b00, 2'b00);
        // R6/R7: port reports
        run_txn(32'h4000_0204, 1'b0, 0, 1, 2'b01, 2'b00);
        run_txn(32'h5000_0308, 1'b1, 0, 1, 2'b10, 2'b00);
        run_txn(32'h6000_040C, 1'b0, 0, 1, 2'b00, 2'b00);
        run_txn(32'h7000_0500, 1'b1, 0, 1, 2'b11, 2'b00);
        // R8/R9: refusal with each width, wrap near end of line
        run_txn(32'h8000_0604, 1'b0, 1, 0, 2'b00, 2'b00);
        run_txn(32'h9000_070C, 1'b1, 1, 0, 2'b00, 2'b01);
        run_txn(32'hA000_0808, 1'b0, 1, 0, 2'b00, 2'b10);
        run_txn(32'hB000_090C, 1'b1, 1, 1, 2'b01, 2'b11);

        for (int t = 0; t < 40; t++) begin
            run_txn($urandom, 1'($urandom_range(0, 1)), ($urandom_range(0, 2) == 0),
                    1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                    2'($urandom_range(0, 3)));
        end

        ended = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule